// File: doc/BRIEF.md
# Depth-Cascade Match Arbiter

This block is the per-device arbitration slice that lets up to eight cascaded search devices share a single result bus. Every device in the chain carries one instance. The instance takes the local search outcome (a hit flag, a same-device multi-hit flag and the highest-priority local location), the lookup type, and a static 3-bit device address. It passes its own hit down the chain on a match output. It also takes in, on a single match input, the merged match outputs of every device above it. Priority is fixed by chain position: a device with a local hit gives way when any upstream device has also hit.

The block is pipelined in two registered stages. In the first stage it captures the operation and publishes the match output. In the second stage it combines the captured result with the match input. From that it decides whether to enable the shared index bus, builds the index word, pulls the shared multi-match line and produces the SRAM controls and the host feedback. Two static strap inputs choose roles. The last-SRAM strap marks the device that owns the SRAM chip-enable and write-enable lines and parks the index bus when it would otherwise float. The last-device strap marks the device that returns hit and completion feedback to the host. Tri-state drivers are modelled as output-enable signals.

Top module: `cascade_match_arbiter`

## Requirements
- R1: While reset is high, every output, including all enables, is 0 after the next clock edge.
- R2: `match_out` is 1 in the cycle after an edge that sampled `op_valid=1` and `local_hit=1`, and is 0 otherwise.
- R3: When the captured operation had a local hit and `match_in` is 0 at the following edge, `index_oe` is 1 after that edge. `index_bus` then holds the local location in bits [14:0], `dev_addr` in bits [17:15] and the lookup type in bits [19:18].
- R4: A device with no last-SRAM strap and a captured local hit keeps `index_oe` at 0 when `match_in` is 1 at the deciding edge.
- R5: A last-SRAM-strapped device that is not the winner drives `index_oe=1` with an all-zero `index_bus` when the deciding cycle has no completed operation, or has a completed operation with no hit locally or upstream.
- R6: `multi_pull` is 1 after the deciding edge exactly when the captured operation had a local hit and either `local_multi` was 1 or `match_in` is 1.
- R7: `ctl_oe` equals the last-SRAM strap. On that device, `sram_ce` is 1 for a completed operation with a hit locally or upstream, and `sram_we` is 1 for a completed learn operation. On any other device both lines are 0.
- R8: `fb_oe` equals the last-device strap. On that device, `lookup_valid` is 1 for every completed operation, and `match_ack` is 1 only when that operation hit locally or upstream. On any other device both lines are 0.
- R9: Operations may be issued on consecutive cycles. Each one produces its own result two edges after it is sampled, and results do not mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 3 | Static device address in the cascade |
| strap_last_sram | input | 1 | Device owns SRAM controls and parks the index bus |
| strap_last_dev | input | 1 | Device owns host feedback lines |
| op_valid | input | 1 | A search result is presented this cycle |
| op_learn | input | 1 | The operation is a learn |
| lookup_type | input | 2 | Lookup width code carried into the index word |
| local_hit | input | 1 | The local array found a hit |
| local_multi | input | 1 | Several local hits (one or several segments) |
| local_loc | input | 15 | Highest-priority local location |
| match_in | input | 1 | Merged match outputs of all upstream devices |
| match_out | output | 1 | Local hit passed to lower-priority devices |
| index_bus | output | 20 | Index word (type, device, location) |
| index_oe | output | 1 | Enable for the shared index bus |
| multi_pull | output | 1 | Pulls the shared wired-OR multi-match line |
| ctl_oe | output | 1 | Enable for the SRAM control lines |
| sram_ce | output | 1 | SRAM chip/output enable |
| sram_we | output | 1 | SRAM write enable |
| fb_oe | output | 1 | Enable for the host feedback lines |
| match_ack | output | 1 | Host feedback: a hit was found |
| lookup_valid | output | 1 | Host feedback: the operation completed |

## Verification
The hardest case to reach is a single device that is at once the last-SRAM owner and holds a local hit while an upstream device also hit. In that case it must yield the bus and still raise the SRAM enable and the multi-match pull. Random stimulus rarely lines up all three inputs in the right two-cycle relation, so directed sequences force it in both strap settings. They also pair a miss with a raised match input, which must not trigger parking. Random back-to-back operations with independently chosen match inputs then exercise the pipeline alignment.

// File: rtl/cma_pkg.sv
package cma_pkg;
  // source selected for the shared index bus in the deciding cycle
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_WIN  = 2'd1,
    DRV_PARK = 2'd2
  } drv_src_e;
endpackage

// File: rtl/cma_capture.sv
module cma_capture #(
  parameter int LOC_W = 15,
  parameter int LT_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_learn,
  input  logic [LT_W-1:0]  lookup_type,
  input  logic             local_hit,
  input  logic             local_multi,
  input  logic [LOC_W-1:0] local_loc,
  output logic             s1_valid,
  output logic             s1_hit,
  output logic             s1_multi,
  output logic             s1_learn,
  output logic [LT_W-1:0]  s1_lt,
  output logic [LOC_W-1:0] s1_loc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_multi <= 1'b0;
      s1_learn <= 1'b0;
      s1_lt    <= '0;
      s1_loc   <= '0;
    end else begin
      s1_valid <= op_valid;
      s1_hit   <= op_valid & local_hit;
      s1_multi <= op_valid & local_hit & local_multi;
      s1_learn <= op_valid & op_learn;
      s1_lt    <= lookup_type;
      s1_loc   <= local_loc;
    end
  end

  assert_hit_out_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && local_hit) |=> s1_hit);
  assert_idle_out_R2: assert property (@(posedge clk) disable iff (rst)
    (!op_valid) |=> (!s1_hit && !s1_valid));
endmodule

// File: rtl/cma_resolve.sv
module cma_resolve
  import cma_pkg::*;
#(
  parameter int LOC_W = 15,
  parameter int DEV_W = 3,
  parameter int LT_W  = 2,
  localparam int IDX_W = LT_W + DEV_W + LOC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             strap_last_sram,
  input  logic             s1_valid,
  input  logic             s1_hit,
  input  logic             s1_multi,
  input  logic [LT_W-1:0]  s1_lt,
  input  logic [LOC_W-1:0] s1_loc,
  input  logic             match_in,
  output logic [IDX_W-1:0] index_bus,
  output logic             index_oe,
  output logic             multi_pull
);
  drv_src_e   src;
  logic       any_hit;
  logic [IDX_W-1:0] win_word;

  assign any_hit  = s1_valid & (s1_hit | match_in);
  assign win_word = {s1_lt, dev_addr, s1_loc};

  always_comb begin
    if (s1_hit && !match_in)
      src = DRV_WIN;
    else if (strap_last_sram && !any_hit)
      src = DRV_PARK;
    else
      src = DRV_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_bus  <= '0;
      index_oe   <= 1'b0;
      multi_pull <= 1'b0;
    end else begin
      index_oe   <= (src != DRV_NONE);
      index_bus  <= (src == DRV_WIN) ? win_word : '0;
      multi_pull <= s1_hit & (s1_multi | match_in);
    end
  end

  assert_yield_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && match_in && !strap_last_sram) |=> !index_oe);
  assert_win_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && !match_in) |=> index_oe);
  assert_multi_dev_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && match_in) |=> multi_pull);
  assert_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (!s1_hit && !strap_last_sram) |=> !index_oe);
endmodule

// File: rtl/cma_ctrl.sv
module cma_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic strap_last_sram,
  input  logic strap_last_dev,
  input  logic s1_valid,
  input  logic s1_hit,
  input  logic s1_learn,
  input  logic match_in,
  output logic ctl_oe,
  output logic sram_ce,
  output logic sram_we,
  output logic fb_oe,
  output logic match_ack,
  output logic lookup_valid
);
  logic glob_hit;
  assign glob_hit = s1_valid & (s1_hit | match_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_oe       <= 1'b0;
      sram_ce      <= 1'b0;
      sram_we      <= 1'b0;
      fb_oe        <= 1'b0;
      match_ack    <= 1'b0;
      lookup_valid <= 1'b0;
    end else begin
      ctl_oe       <= strap_last_sram;
      sram_ce      <= strap_last_sram & glob_hit;
      sram_we      <= strap_last_sram & s1_learn;
      fb_oe        <= strap_last_dev;
      match_ack    <= strap_last_dev & glob_hit;
      lookup_valid <= strap_last_dev & s1_valid;
    end
  end

  assert_fb_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!strap_last_dev) |=> (!fb_oe && !match_ack && !lookup_valid));
  assert_learn_we_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_learn && strap_last_sram) |=> sram_we);
  assert_ctl_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!strap_last_sram) |=> (!ctl_oe && !sram_ce && !sram_we));
endmodule

// File: rtl/cascade_match_arbiter.sv
module cascade_match_arbiter #(
  parameter int LOC_W = 15,
  parameter int DEV_W = 3,
  parameter int LT_W  = 2,
  localparam int IDX_W = LT_W + DEV_W + LOC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             strap_last_sram,
  input  logic             strap_last_dev,
  input  logic             op_valid,
  input  logic             op_learn,
  input  logic [LT_W-1:0]  lookup_type,
  input  logic             local_hit,
  input  logic             local_multi,
  input  logic [LOC_W-1:0] local_loc,
  input  logic             match_in,
  output logic             match_out,
  output logic [IDX_W-1:0] index_bus,
  output logic             index_oe,
  output logic             multi_pull,
  output logic             ctl_oe,
  output logic             sram_ce,
  output logic             sram_we,
  output logic             fb_oe,
  output logic             match_ack,
  output logic             lookup_valid
);
  logic             s1_valid, s1_hit, s1_multi, s1_learn;
  logic [LT_W-1:0]  s1_lt;
  logic [LOC_W-1:0] s1_loc;

  cma_capture #(.LOC_W(LOC_W), .LT_W(LT_W)) capture_i (
    .clk(clk), .rst(rst),
    .op_valid(op_valid), .op_learn(op_learn), .lookup_type(lookup_type),
    .local_hit(local_hit), .local_multi(local_multi), .local_loc(local_loc),
    .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_multi(s1_multi),
    .s1_learn(s1_learn), .s1_lt(s1_lt), .s1_loc(s1_loc)
  );

  // registered local hit goes straight down the chain
  assign match_out = s1_hit;

  cma_resolve #(.LOC_W(LOC_W), .DEV_W(DEV_W), .LT_W(LT_W)) resolve_i (
    .clk(clk), .rst(rst),
    .dev_addr(dev_addr), .strap_last_sram(strap_last_sram),
    .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_multi(s1_multi),
    .s1_lt(s1_lt), .s1_loc(s1_loc), .match_in(match_in),
    .index_bus(index_bus), .index_oe(index_oe), .multi_pull(multi_pull)
  );

  cma_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .strap_last_sram(strap_last_sram), .strap_last_dev(strap_last_dev),
    .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_learn(s1_learn),
    .match_in(match_in),
    .ctl_oe(ctl_oe), .sram_ce(sram_ce), .sram_we(sram_we),
    .fb_oe(fb_oe), .match_ack(match_ack), .lookup_valid(lookup_valid)
  );
endmodule

// File: tb/cascade_match_arbiter_tb.sv
`timescale 1ns/1ps
module cascade_match_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  dev_addr = 3'd0;
  logic        strap_last_sram = 1'b0, strap_last_dev = 1'b0;
  logic        op_valid = 1'b0, op_learn = 1'b0, local_hit = 1'b0, local_multi = 1'b0;
  logic [1:0]  lookup_type = 2'd0;
  logic [14:0] local_loc = '0;
  logic        match_in = 1'b0;
  logic        match_out, index_oe, multi_pull, ctl_oe, sram_ce, sram_we;
  logic        fb_oe, match_ack, lookup_valid;
  logic [19:0] index_bus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic v; logic h; logic m; logic l; logic [1:0] lt; logic [14:0] loc;
  } op_t;

  op_t o1, o2;
  logic mi_prev;

  always #2.5 clk = ~clk;

  cascade_match_arbiter dut_i (
    .clk(clk), .rst(rst), .dev_addr(dev_addr),
    .strap_last_sram(strap_last_sram), .strap_last_dev(strap_last_dev),
    .op_valid(op_valid), .op_learn(op_learn), .lookup_type(lookup_type),
    .local_hit(local_hit), .local_multi(local_multi), .local_loc(local_loc),
    .match_in(match_in), .match_out(match_out), .index_bus(index_bus),
    .index_oe(index_oe), .multi_pull(multi_pull), .ctl_oe(ctl_oe),
    .sram_ce(sram_ce), .sram_we(sram_we), .fb_oe(fb_oe),
    .match_ack(match_ack), .lookup_valid(lookup_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_win(op_t o, logic mi);
    return o.v & o.h & !mi;
  endfunction
  function automatic logic f_glob(op_t o, logic mi);
    return o.v & (o.h | mi);
  endfunction
  function automatic logic f_oe(op_t o, logic mi, logic ls);
    return f_win(o, mi) | (ls & !f_glob(o, mi));
  endfunction
  function automatic logic [19:0] f_idx(op_t o, logic mi, logic [2:0] da);
    return f_win(o, mi) ? {o.lt, da, o.loc} : 20'd0;
  endfunction

  // check outputs for the ops in flight, then apply a new op and match input
  task automatic step(input op_t nxt, input logic mi);
    @(negedge clk);
    chk("R2 match_out", match_out, o1.v & o1.h);
    chk("R3/R4/R5 index_oe", index_oe, f_oe(o2, mi_prev, strap_last_sram));
    chk("R3 index_bus", index_bus, f_idx(o2, mi_prev, dev_addr));
    chk("R6 multi_pull", multi_pull, o2.v & o2.h & (o2.m | mi_prev));
    chk("R7 ctl_oe", ctl_oe, strap_last_sram);
    chk("R7 sram_ce", sram_ce, strap_last_sram & f_glob(o2, mi_prev));
    chk("R7 sram_we", sram_we, strap_last_sram & o2.v & o2.l);
    chk("R8 fb_oe", fb_oe, strap_last_dev);
    chk("R8 match_ack", match_ack, strap_last_dev & f_glob(o2, mi_prev));
    chk("R8 lookup_valid", lookup_valid, strap_last_dev & o2.v);
    op_valid = nxt.v; local_hit = nxt.h; local_multi = nxt.m; op_learn = nxt.l;
    lookup_type = nxt.lt; local_loc = nxt.loc;
    match_in = mi;
    o2 = o1; o1 = nxt; mi_prev = mi;
  endtask

  function automatic op_t mk(logic v, logic h, logic m, logic l, logic [1:0] lt, logic [14:0] loc);
    op_t o;
    o.v = v; o.h = h; o.m = m; o.l = l; o.lt = lt; o.loc = loc;
    return o;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_valid = 0; local_hit = 0; local_multi = 0; op_learn = 0; match_in = 0;
    lookup_type = 0; local_loc = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {match_out, index_oe, multi_pull, ctl_oe, sram_ce,
        sram_we, fb_oe, match_ack, lookup_valid}, 0);
    chk("R1 reset index_bus", index_bus, 0);
    rst = 1'b0;
    o1 = '0; o2 = '0; mi_prev = 1'b0;
  endtask

  task automatic run_cfg(input logic ls, input logic ld, input logic [2:0] da);
    op_t z;
    z = '0;
    strap_last_sram = ls; strap_last_dev = ld; dev_addr = da;
    do_reset();
    // directed: idle parking, win, yield with upstream hit, miss with upstream hit
    step(z, 1'b0);
    step(mk(1, 1, 0, 0, 2'd3, 15'h7fff), 1'b0);   // win, full location (R3)
    step(mk(1, 1, 0, 1, 2'd1, 15'h0001), 1'b0);   // no upstream hit for prior op
    step(mk(1, 0, 0, 0, 2'd2, 15'h1234), 1'b1);   // yield for prior hit (R4, R6)
    step(mk(1, 0, 0, 1, 2'd0, 15'h0000), 1'b1);   // miss with upstream hit
    step(mk(1, 1, 1, 0, 2'd2, 15'h2aaa), 1'b0);   // miss, no upstream: park (R5)
    step(z, 1'b1);                                // local multi, upstream hit
    step(z, 1'b0);
    step(z, 1'b0);
    // random back-to-back traffic (R9)
    for (int i = 0; i < 400; i++) begin
      op_t r;
      r.v   = ($urandom % 4) != 0;
      r.h   = r.v & (($urandom % 2) != 0);
      r.m   = r.h & (($urandom % 4) == 0);
      r.l   = r.v & (($urandom % 5) == 0);
      r.lt  = 2'($urandom);
      r.loc = 15'($urandom);
      step(r, ($urandom % 5) < 2);
    end
    step(z, 1'b0);
    step(z, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4177));
    run_cfg(1'b0, 1'b0, 3'd2);
    run_cfg(1'b1, 1'b1, 3'd7);
    run_cfg(1'b1, 1'b0, 3'd5);
    run_cfg(1'b0, 1'b1, 3'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule